// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address after a translation-buffer miss by reading the in-memory mapping tables. A request carries a 32-bit virtual address, the access type (read or write, user or supervisor) and the frame number of the top-level table. The walker reads the top-level entry first. When that entry maps a 4 MB region directly, the walk stops there. Otherwise it reads the second-level entry that the first one points to.

Each walk ends in one of two ways. The walker can pulse `done` with a physical address, the permission bits and the page size, ready to load into a translation buffer. It can instead pulse `fault` with a code that separates a missing mapping from a permission violation, and with the level at which the walk stopped. A successful walk also keeps the final entry's usage bits up to date. It marks the entry as referenced and, for a store, as modified. It does this by writing the entry back over the same memory port, and only when a bit actually changes.

The memory port allows one access at a time. The walker raises `mem_req` and holds the address, direction and write data steady until the memory answers with a one-cycle `mem_ack`. For a read, `mem_rdata` is valid in the cycle of the `mem_ack` pulse.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read at word address {dir_frame, va[31:22], 2'b00}. A second-level read, when one is needed, goes to {top_entry[31:12], va[21:12], 2'b00}.
- R2: Entry bit 0 means "present". If this bit is clear in the top-level entry, the walk ends with `fault`, `fault_prot`=0 and `fault_lvl`=0. If it is clear in the second-level entry, the walk ends the same way with `fault_lvl`=1. No write-back follows either fault.
- R3: A present top-level entry with bit 7 set is a 4 MB mapping. There is no second read. `out_paddr` = {entry[31:22], va[21:0]} and `out_large`=1.
- R4: A present second-level entry gives `out_paddr` = {pte[31:12], va[11:0]} and `out_large`=0.
- R5: Bit 1 of an entry grants write access and bit 2 grants user access. For a 4 KB page, each right is the AND of that bit in both entries. A write without the write right, or a user access without the user right, ends with `fault`, `fault_prot`=1 and `fault_lvl` set to the level of the final entry. No write-back follows.
- R6: After a successful walk, if bit 5 (accessed) of the final entry is clear, the walker writes the entry back to its own address with bit 5 set, before it pulses `done`. If no bit changes, no write is made.
- R7: For a write access, the write-back also sets bit 6 (dirty) in the final entry. `out_dirty` reports the final entry's dirty bit after the update.
- R8: On `done`, `out_perm` = {cache-disable bit 4, write-through bit 3, user right, write right}. The bit-4 and bit-3 values come from the final entry, and the two rights are the effective rights from R5.
- R9: The walker takes a request only while it is idle. `busy` stays high from the cycle after acceptance until the cycle in which exactly one of `done` or `fault` pulses for one cycle. A `req_valid` seen while the walker is busy has no effect. A request presented during the cycle of a `done` or `fault` pulse is accepted.
- R10: While reset is applied, `busy`, `done`, `fault` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is made in user mode |
| dir_frame | input | 20 | Frame number of the top-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation valid |
| fault | output | 1 | One-cycle pulse: walk failed |
| fault_prot | output | 1 | 0 = not present, 1 = permission violation |
| fault_lvl | output | 1 | Level at which the walk stopped (0 top, 1 second) |
| out_paddr | output | 32 | Translated physical address |
| out_large | output | 1 | Mapping is a 4 MB page |
| out_perm | output | 4 | {cache-disable, write-through, user, write} |
| out_dirty | output | 1 | Final entry's dirty bit after the update |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Two events can fall in the same cycle: a walk finishing, shown by the `done` or `fault` pulse, and a new request being accepted. The bench provokes this by presenting every following request during the cycle of the previous result pulse. It then checks that the new walk starts with the top-level read at the correct address and ends with the result computed for it. A second pairing is a request that arrives in the middle of a walk. That request must not change the number or the addresses of the memory accesses, and must not change the result that is reported.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [19:0] dir_frame,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        fault_prot,
  output logic        fault_lvl,
  output logic [31:0] out_paddr,
  output logic        out_large,
  output logic [3:0]  out_perm,
  output logic        out_dirty,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int B_P = 0, B_W = 1, B_U = 2, B_WT = 3, B_CD = 4, B_A = 5, B_D = 6, B_L = 7;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_WB} st_t;
  st_t st;

  logic [31:0] va_q, addr_q, wb_q;
  logic        wr_q, usr_q, pw_q, pu_q;

  wire  [31:0] e      = mem_rdata;
  wire         at_dir = (st == S_DIR);
  wire         is_big = at_dir & e[B_L];
  wire         w_eff  = at_dir ? e[B_W] : (pw_q & e[B_W]);
  wire         u_eff  = at_dir ? e[B_U] : (pu_q & e[B_U]);
  wire         prot   = (wr_q & ~w_eff) | (usr_q & ~u_eff);
  wire  [31:0] upd    = e | (32'd1 << B_A) | (wr_q ? (32'd1 << B_D) : 32'd0);
  wire         final_rd = mem_ack & e[B_P] & ((st == S_TBL) | is_big);

  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      fault <= 1'b0;
      fault_prot <= 1'b0;
      fault_lvl <= 1'b0;
      out_paddr <= '0;
      out_large <= 1'b0;
      out_perm <= '0;
      out_dirty <= 1'b0;
      va_q <= '0;
      addr_q <= '0;
      wb_q <= '0;
      wr_q <= 1'b0;
      usr_q <= 1'b0;
      pw_q <= 1'b0;
      pu_q <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          addr_q <= {dir_frame, req_vaddr[31:22], 2'b00};
          st     <= S_DIR;
        end
        S_DIR, S_TBL: if (mem_ack) begin
          if (!e[B_P]) begin
            fault <= 1'b1;
            fault_prot <= 1'b0;
            fault_lvl <= ~at_dir;
            st <= S_IDLE;
          end else if (at_dir && !e[B_L]) begin
            pw_q   <= e[B_W];
            pu_q   <= e[B_U];
            addr_q <= {e[31:12], va_q[21:12], 2'b00};
            st     <= S_TBL;
          end else if (prot) begin
            fault <= 1'b1;
            fault_prot <= 1'b1;
            fault_lvl <= ~at_dir;
            st <= S_IDLE;
          end else begin
            out_paddr <= is_big ? {e[31:22], va_q[21:0]} : {e[31:12], va_q[11:0]};
            out_large <= is_big;
            out_perm  <= {e[B_CD], e[B_WT], u_eff, w_eff};
            out_dirty <= upd[B_D];
            wb_q      <= upd;
            if (upd != e) st <= S_WB;
            else begin
              done <= 1'b1;
              st <= S_IDLE;
            end
          end
        end
        S_WB: if (mem_ack) begin
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R9
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done && !fault); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> mem_wdata[B_A]); // R6
  AST_WB_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(mem_we) |-> $stable(mem_addr)); // R6
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we && wr_q |-> mem_wdata[B_D]); // R7
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !$past(mem_we)); // R5
  AST_WB_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(mem_we) |-> $past(mem_ack) && $past(mem_rdata[B_P])); // R6
  AST_DONE_HAD_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    final_rd && !prot && !mem_we |=> done || mem_we); // R6
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = 0;
  logic [19:0] dir_frame = 20'h00100;
  logic busy, done, fault, fault_prot, fault_lvl, out_large, out_dirty;
  logic [31:0] out_paddr;
  logic [3:0] out_perm;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (.*);

  logic [31:0] mem [logic [31:0]];
  int nreads, nwrites, waitc;
  logic [31:0] rd_a0, rd_a1, wr_a, wr_d;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  initial begin mem_ack = 0; mem_rdata = 0; waitc = 0; end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (waitc == 0) begin
        mem_ack <= 1'b1;
        waitc <= $urandom % 3;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          nwrites <= nwrites + 1; wr_a <= mem_addr; wr_d <= mem_wdata;
        end else begin
          mem_rdata <= rdm(mem_addr);
          if (nreads == 0) rd_a0 <= mem_addr; else rd_a1 <= mem_addr;
          nreads <= nreads + 1;
        end
      end else waitc <= waitc - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // expected result
  bit e_fault, e_prot, e_lvl, e_large, e_dirty, e_wb;
  logic [31:0] e_pa, e_a0, e_a1, e_wa, e_wd;
  logic [3:0] e_perm;
  int e_nr;

  task automatic model(input logic [31:0] va, input bit wr, input bit us);
    logic [31:0] pde, pte, fin;
    bit w, u;
    e_fault = 0; e_prot = 0; e_lvl = 0; e_wb = 0; e_large = 0;
    e_a0 = {dir_frame, va[31:22], 2'b00};
    pde = rdm(e_a0);
    e_nr = 1;
    e_a1 = {pde[31:12], va[21:12], 2'b00};
    if (!pde[0]) begin e_fault = 1; return; end
    if (pde[7]) begin
      fin = pde; e_large = 1; w = pde[1]; u = pde[2]; e_wa = e_a0;
      e_pa = {pde[31:22], va[21:0]};
    end else begin
      e_nr = 2; e_lvl = 1;
      pte = rdm(e_a1);
      if (!pte[0]) begin e_fault = 1; return; end
      fin = pte; w = pde[1] & pte[1]; u = pde[2] & pte[2]; e_wa = e_a1;
      e_pa = {pte[31:12], va[11:0]};
    end
    if ((wr && !w) || (us && !u)) begin e_fault = 1; e_prot = 1; return; end
    e_wd = fin | 32'h20 | (wr ? 32'h40 : 32'h0);
    e_wb = (e_wd != fin);
    e_dirty = e_wd[6];
    e_perm = {fin[4], fin[3], u, w};
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit us,
                      input bit poke, input string tag);
    int k = 0;
    model(va, wr, us);
    nreads = 0; nwrites = 0;
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R9", {tag, " busy after accept"}, busy, 1);
    do begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin
        req_valid = 1; req_vaddr = ~va; req_write = ~wr; req_user = 0;
      end
      if (k == 2) req_valid = 0;
    end while (!(done || fault) && k < 60);
    req_valid = 0;
    chk(k < 60, "R9", {tag, " completion"}, k, 60);
    chk(!busy && (done ^ fault), "R9", {tag, " single outcome, busy low"}, {busy, done, fault}, 0);
    chk(nreads == e_nr, e_large ? "R3" : "R1", {tag, " read count"}, nreads, e_nr);
    chk(rd_a0 == e_a0, "R1", {tag, " top entry address"}, rd_a0, e_a0);
    if (e_nr == 2) chk(rd_a1 == e_a1, "R1", {tag, " second entry address"}, rd_a1, e_a1);
    if (e_fault) begin
      chk(fault, e_prot ? "R5" : "R2", {tag, " fault raised"}, fault, 1);
      chk(fault_prot == e_prot && fault_lvl == e_lvl, e_prot ? "R5" : "R2",
          {tag, " fault code/level"}, {fault_prot, fault_lvl}, {e_prot, e_lvl});
      chk(nwrites == 0, e_prot ? "R5" : "R2", {tag, " no write-back on fault"}, nwrites, 0);
    end else begin
      chk(done, "R4", {tag, " done raised"}, done, 1);
      chk(out_paddr == e_pa, e_large ? "R3" : "R4", {tag, " physical address"}, out_paddr, e_pa);
      chk(out_large == e_large, "R3", {tag, " page size"}, out_large, e_large);
      chk(out_perm == e_perm, "R8", {tag, " permissions"}, out_perm, e_perm);
      chk(out_dirty == e_dirty, "R7", {tag, " dirty report"}, out_dirty, e_dirty);
      chk(nwrites == (e_wb ? 1 : 0), "R6", {tag, " write-back count"}, nwrites, e_wb);
      if (e_wb) begin
        chk(wr_a == e_wa, "R6", {tag, " write-back address"}, wr_a, e_wa);
        chk(wr_d == e_wd, wr ? "R7" : "R6", {tag, " write-back data"}, wr_d, e_wd);
      end
    end
  endtask

  function automatic logic [31:0] tadr(input logic [31:0] pde, input logic [31:0] va);
    return {pde[31:12], va[21:12], 2'b00};
  endfunction
  function automatic logic [31:0] dadr(input logic [31:0] va);
    return {dir_frame, va[31:22], 2'b00};
  endfunction

  initial begin
    logic [31:0] va, pde, pte;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R10", "reset outputs", {busy, done, fault, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R10", "idle after reset", {busy, mem_req}, 0);

    // R2 missing top entry
    va = 32'h0040_1234;
    walk(va, 0, 0, 0, "R2 top absent");
    // R4/R6 4K page, A clear, read
    pde = 32'h0020_0007; mem[dadr(va)] = pde;
    mem[tadr(pde, va)] = 32'hABCDE01F;
    walk(va, 0, 1, 0, "R4 4K read");
    // R6 A already set: no write
    walk(va, 0, 1, 0, "R6 no rewrite");
    // R7 store sets D
    walk(va, 1, 1, 0, "R7 store");
    // R2 missing second-level
    mem[tadr(pde, va)] = 32'h1234_5006;
    walk(va, 0, 0, 0, "R2 second absent");
    // R5 write to read-only; user on supervisor page
    mem[tadr(pde, va)] = 32'h1234_5005;
    walk(va, 1, 0, 0, "R5 read-only");
    mem[tadr(pde, va)] = 32'h1234_5003;
    walk(va, 0, 1, 0, "R5 supervisor");
    // R5 top-level revokes write
    va = 32'h0080_0000;
    pde = 32'h0030_0005; mem[dadr(va)] = pde;
    mem[tadr(pde, va)] = 32'h5555_5007;
    walk(va, 1, 0, 0, "R5 top write clear");
    // R3 large page, store
    va = 32'h0C3F_FABC;
    mem[dadr(va)] = 32'h8840_0087;
    walk(va, 1, 0, 0, "R3 large store");
    mem[dadr(va)] = 32'h8840_0085;
    walk(va, 1, 0, 0, "R5 large read-only");
    // R9 request during walk ignored
    va = 32'h0000_3000;
    pde = 32'h0040_0007; mem[dadr(va)] = pde;
    mem[tadr(pde, va)] = 32'h7777_7007;
    walk(va, 0, 0, 1, "R9 ignore mid-walk");

    for (int i = 0; i < 400; i++) begin
      va = $urandom;
      pde = {$urandom} & 32'hFFFF_F0FF;
      if ($urandom % 8 != 0) pde[0] = 1'b1;
      pde[7] = ($urandom % 4 == 0);
      if ($urandom % 3 != 0) pde[2:1] = 2'b11;
      mem[dadr(va)] = pde;
      pte = {$urandom} & 32'hFFFF_F17F;
      if ($urandom % 8 != 0) pte[0] = 1'b1;
      if ($urandom % 3 != 0) pte[2:1] = 2'b11;
      if (!pde[7]) mem[tadr(pde, va)] = pte;
      walk(va, $urandom % 2, $urandom % 2, ($urandom % 6 == 0), "random");
      if ($urandom % 4 == 0) @(negedge clk);
    end
    finish_run();
  end
endmodule